// File: doc/BRIEF.md
# Token-Passing Readout Sequencer for a Shared Chain Bus

This block sits in each front-end chip of a chain whose members all share one serial data bus. It moves through four phases in a fixed order: acquisition, conversion, readout and idle. During acquisition a bunch-crossing counter runs from zero, and every accepted trigger stores the current count in the next free slot of a small event store. During conversion the external converter writes per-channel amplitude values and a gain flag into the same slots. The chip then waits for a token from the chip upstream. When the token arrives it drives its stored events onto the shared bus, most significant bit first, and then hands the token to the chip downstream.

A chip that recorded no events hands the token on at once, so an empty chip adds one cycle to the chain's readout time. When its readout ends the chip clears its own event count and returns to idle, ready for the next acquisition. A chain of eight chips shares one bus. Bus ownership is never arbitrated, because only the token holder drives the bus.

Top module: `tokring_rdout`

## Requirements
- R1: Triggers are accepted only in the acquisition phase. Conversion writes are accepted only in the conversion phase. A token is honoured only while the chip waits for it after conversion. A trigger in idle and a conversion write during acquisition change no stored data.
- R2: When `acq_en` rises in idle, the bunch-crossing counter is set to 0. During acquisition it advances by one on each cycle with `bx_tick` high, and it wraps from 4095 to 0.
- R3: Each accepted trigger stores the current bunch-crossing count in the next free slot, in trigger order. The store holds at most DEPTH (16) events, and triggers that arrive while it is full are dropped.
- R4: A chip holding zero events raises `token_out` in the cycle after it samples `token_in`, and it never raises `bus_oe`.
- R5: A chip holding N>0 events raises `bus_oe` in the cycle after it samples `token_in` and holds it for exactly N×38 cycles. `token_out` is then high for exactly one cycle, the first cycle after `bus_oe` falls.
- R6: Events leave in slot order as 38-bit words, sent MSB first. Each word holds the 12-bit bunch-crossing tag, then for channel 0 and then channel 1 the 12-bit value (MSB first) followed by the gain bit.
- R7: At the end of its readout the chip clears its event count. The next acquisition fills the store again from slot 0, and an acquisition with no triggers passes the token at once.
- R8: A `token_in` pulse during acquisition or conversion causes neither `bus_oe` nor `token_out`.
- R9: After reset `bus_oe`, `bus_dout` and `token_out` are 0 and the chip is idle.
- R10: `bus_dout` is 0 whenever `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | Acquisition window from the DAQ: high for acquisition, its fall starts conversion |
| conv_done | input | 1 | Pulse ending the conversion phase |
| bx_tick | input | 1 | Bunch-crossing strobe that advances the counter |
| trig | input | 1 | Auto-trigger pulse |
| conv_wr | input | 1 | Conversion result write strobe |
| conv_slot | input | 4 | Event slot of the conversion result |
| conv_ch | input | 1 | Channel of the conversion result |
| conv_val | input | 12 | Converted amplitude |
| conv_gain | input | 1 | Gain range flag of the result |
| token_in | input | 1 | Token pulse from the upstream chip |
| token_out | output | 1 | Token pulse to the downstream chip |
| bus_oe | output | 1 | Output enable for the shared bus |
| bus_dout | output | 1 | Serial data onto the shared bus |

## Verification
The bound checker watches, on every cycle, the relations between signals that hold at all times. Bus data stays quiet while output enable is low. Output enable rises only after a token. Token-out and output enable are never high together, and every fall of output enable passes the token. An empty chip forwards the token at once. The counter steps by one per tick during acquisition, a trigger while the store is full or during conversion leaves the event count unchanged, and the count is zero whenever the token leaves.

Some behaviour can only be shown by the bench's scenarios: the bit-exact content and order of the serial words, the exact length of the enable window, the wrap of the counter after 4097 ticks, the dropping of the 17th and 18th triggers, and the refill of the store from slot 0 after a readout.

// File: rtl/tokring_pkg.sv
package tokring_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ACQ,
      PH_CONV,
      PH_WAIT,
      PH_SEND
   } phase_e;
endpackage

// File: rtl/tokring_bxcnt.sv
// Bunch-crossing tag counter; wraps naturally at 2**BXW-1.
module tokring_bxcnt #(
   parameter int BXW = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           tick,
   output logic [BXW-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tokring_evmem.sv
// Event store: tag per slot, per-channel value+gain field per slot.
module tokring_evmem #(
   parameter int DEPTH = 16,
   parameter int BXW   = 12,
   parameter int NCH   = 2,
   parameter int ADCW  = 12,
   localparam int SLW  = $clog2(DEPTH),
   localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int CNTW = $clog2(DEPTH + 1),
   localparam int FW   = ADCW + 1,
   localparam int W    = BXW + NCH * FW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            tag_we,
   input  logic [BXW-1:0]  tag,
   input  logic            conv_we,
   input  logic [SLW-1:0]  conv_slot,
   input  logic [CHW-1:0]  conv_ch,
   input  logic [ADCW-1:0] conv_val,
   input  logic            conv_gain,
   input  logic [SLW-1:0]  rd_addr,
   output logic [CNTW-1:0] count,
   output logic [W-1:0]    rd_word
);
   logic [BXW-1:0] tag_mem [DEPTH];
   logic [FW-1:0]  fld_rd  [NCH];
   logic           full;

   assign full = (count == CNTW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n)                count <= '0;
      else if (clear)            count <= '0;
      else if (tag_we && !full)  count <= count + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (tag_we && !full) tag_mem[count[SLW-1:0]] <= tag;
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic [FW-1:0] fld [DEPTH];
      always_ff @(posedge clk) begin
         if (conv_we && conv_ch == CHW'(ch)) fld[conv_slot] <= {conv_val, conv_gain};
      end
      assign fld_rd[ch] = fld[rd_addr];
   end

   always_comb begin
      rd_word = '0;
      rd_word[W-1 -: BXW] = tag_mem[rd_addr];
      for (int ch = 0; ch < NCH; ch++) begin
         rd_word[W-1-BXW-ch*FW -: FW] = fld_rd[ch];
      end
   end
endmodule

// File: rtl/tokring_ser.sv
// MSB-first shifter with bit counter; load takes priority over shift.
module tokring_ser #(
   parameter int W    = 38,
   localparam int BCW = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] word,
   input  logic         run,
   output logic         msb,
   output logic         last
);
   logic [W-1:0]   sh;
   logic [BCW-1:0] bcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         bcnt <= '0;
      end else if (load) begin
         sh   <= word;
         bcnt <= '0;
      end else if (run) begin
         sh   <= sh << 1;
         bcnt <= bcnt + 1'b1;
      end
   end

   assign msb  = sh[W-1];
   assign last = (bcnt == BCW'(W - 1));
endmodule

// File: rtl/tokring_rdout.sv
module tokring_rdout
   import tokring_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int BXW   = 12,
   parameter int NCH   = 2,
   parameter int ADCW  = 12
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  acq_en,
   input  logic                                  conv_done,
   input  logic                                  bx_tick,
   input  logic                                  trig,
   input  logic                                  conv_wr,
   input  logic [$clog2(DEPTH)-1:0]              conv_slot,
   input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] conv_ch,
   input  logic [ADCW-1:0]                       conv_val,
   input  logic                                  conv_gain,
   input  logic                                  token_in,
   output logic                                  token_out,
   output logic                                  bus_oe,
   output logic                                  bus_dout
);
   localparam int SLW  = $clog2(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);
   localparam int W    = BXW + NCH * (ADCW + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (BXW < 1 || ADCW < 1 || NCH < 1) begin : g_bad_width
      $error("BXW, ADCW and NCH must be positive");
   end

   phase_e          phase_q;
   logic [BXW-1:0]  bx_val;
   logic [CNTW-1:0] ev_cnt;
   logic [SLW-1:0]  rd_idx, rd_addr;
   logic [W-1:0]    rd_word;
   logic            tok_q;
   logic            bx_clr, bx_inc, tag_we, conv_we_i;
   logic            start, skip, word_end, last_word, done;
   logic            ser_load, ser_run, ser_msb, ser_last;

   always_comb begin
      bx_clr    = (phase_q == PH_IDLE) && acq_en;
      bx_inc    = (phase_q == PH_ACQ) && bx_tick;
      tag_we    = (phase_q == PH_ACQ) && trig;
      conv_we_i = (phase_q == PH_CONV) && conv_wr;
      start     = (phase_q == PH_WAIT) && token_in && (ev_cnt != '0);
      skip      = (phase_q == PH_WAIT) && token_in && (ev_cnt == '0);
      word_end  = (phase_q == PH_SEND) && ser_last;
      last_word = (rd_idx == SLW'(ev_cnt - 1'b1));
      done      = word_end && last_word;
      rd_addr   = start ? '0 : rd_idx + 1'b1;
      ser_load  = start || (word_end && !last_word);
      ser_run   = (phase_q == PH_SEND);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (acq_en)    phase_q <= PH_ACQ;
            PH_ACQ:  if (!acq_en)   phase_q <= PH_CONV;
            PH_CONV: if (conv_done) phase_q <= PH_WAIT;
            PH_WAIT: begin
               if (start)     phase_q <= PH_SEND;
               else if (skip) phase_q <= PH_IDLE;
            end
            PH_SEND: if (done)      phase_q <= PH_IDLE;
            default:                phase_q <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx <= '0;
         tok_q  <= 1'b0;
      end else begin
         tok_q <= done || skip;
         if (start)                       rd_idx <= '0;
         else if (word_end && !last_word) rd_idx <= rd_idx + 1'b1;
      end
   end

   tokring_bxcnt #(.BXW(BXW)) u_bx (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (bx_clr),
      .tick (bx_inc),
      .cnt  (bx_val)
   );

   tokring_evmem #(.DEPTH(DEPTH), .BXW(BXW), .NCH(NCH), .ADCW(ADCW)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (done || skip),
      .tag_we   (tag_we),
      .tag      (bx_val),
      .conv_we  (conv_we_i),
      .conv_slot(conv_slot),
      .conv_ch  (conv_ch),
      .conv_val (conv_val),
      .conv_gain(conv_gain),
      .rd_addr  (rd_addr),
      .count    (ev_cnt),
      .rd_word  (rd_word)
   );

   tokring_ser #(.W(W)) u_ser (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ser_load),
      .word (rd_word),
      .run  (ser_run),
      .msb  (ser_msb),
      .last (ser_last)
   );

   assign token_out = tok_q;
   assign bus_oe    = (phase_q == PH_SEND);
   assign bus_dout  = bus_oe && ser_msb;
endmodule

// File: rtl/tokring_rdout_chk.sv
module tokring_rdout_chk
   import tokring_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int BXW   = 12,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            token_in,
   input logic            token_out,
   input logic            bus_oe,
   input logic            bus_dout,
   input logic            bx_tick,
   input logic            trig,
   input phase_e          phase,
   input logic [CNTW-1:0] count,
   input logic [BXW-1:0]  bx
);
   // R4
   empty_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && token_in && count == '0) |=> (token_out && !bus_oe));
   // R5
   oe_after_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> $past(token_in));
   // R5
   tok_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      token_out |-> !bus_oe);
   // R5
   oe_end_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_oe) |-> token_out);
   // R10
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> !bus_dout);
   // R2
   bx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ACQ && bx_tick) |=> (bx == BXW'($past(bx) + 1'b1)));
   // R3
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ACQ && trig && count == CNTW'(DEPTH)) |=> $stable(count));
   // R1
   conv_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CONV && trig) |=> $stable(count));
   // R7
   tok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      token_out |-> (count == '0));
endmodule

bind tokring_rdout tokring_rdout_chk #(.DEPTH(DEPTH), .BXW(BXW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .token_in (token_in),
   .token_out(token_out),
   .bus_oe   (bus_oe),
   .bus_dout (bus_dout),
   .bx_tick  (bx_tick),
   .trig     (trig),
   .phase    (phase_q),
   .count    (ev_cnt),
   .bx       (bx_val)
);

// File: tb/tokring_rdout_bench.sv
module tokring_rdout_bench;
   localparam int W = 38;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acq_en = 0, conv_done = 0, bx_tick = 0, trig = 0, conv_wr = 0;
   logic [3:0]  conv_slot = 0;
   logic [0:0]  conv_ch = 0;
   logic [11:0] conv_val = 0;
   logic        conv_gain = 0, token_in = 0;
   logic        token_out, bus_oe, bus_dout;

   int total = 0, bad = 0;
   bit finished = 0;
   bit exp_q[$];
   int tags [16];
   logic [11:0] mval  [16][2];
   logic        mgain [16][2];
   int nev, bxm;

   always #10 clk = ~clk;

   tokring_rdout u_tokring_rdout (
      .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .conv_done(conv_done),
      .bx_tick(bx_tick), .trig(trig), .conv_wr(conv_wr), .conv_slot(conv_slot),
      .conv_ch(conv_ch), .conv_val(conv_val), .conv_gain(conv_gain),
      .token_in(token_in), .token_out(token_out), .bus_oe(bus_oe), .bus_dout(bus_dout)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: scoreboard pops one expected bit per enabled cycle (R6, R10)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (bus_oe) begin
            if (exp_q.size() == 0) check(0, "R6 unexpected bit", int'(bus_dout), -1);
            else begin
               automatic bit e = exp_q.pop_front();
               check(bus_dout == e, "R6 serial bit", int'(bus_dout), int'(e));
            end
         end else if (bus_dout !== 1'b0) begin
            check(0, "R10 dout while disabled", int'(bus_dout), 0);
         end
      end
   end

   task automatic begin_acq();
      acq_en = 1; @(negedge clk);
      nev = 0; bxm = 0;
   endtask

   task automatic ticks(input int n);
      bx_tick = 1;
      repeat (n) @(negedge clk);
      bx_tick = 0;
      bxm = (bxm + n) % 4096;
   endtask

   task automatic fire();
      trig = 1; @(negedge clk); trig = 0;
      if (nev < 16) begin tags[nev] = bxm; nev++; end
   endtask

   task automatic end_acq();
      acq_en = 0; @(negedge clk);
   endtask

   task automatic cwrite(input int s, input int ch, input logic [11:0] v, input logic g);
      conv_wr = 1; conv_slot = 4'(s); conv_ch = 1'(ch); conv_val = v; conv_gain = g;
      @(negedge clk);
      conv_wr = 0;
   endtask

   task automatic fill(input int seed, input bit skip00);
      for (int s = 0; s < nev; s++)
         for (int ch = 0; ch < 2; ch++) begin
            if (!(skip00 && s == 0 && ch == 0)) begin
               mval[s][ch]  = 12'((s * 397 + ch * 1231 + seed * 77) & 12'hfff);
               mgain[s][ch] = 1'((s + ch + seed) & 1);
               cwrite(s, ch, mval[s][ch], mgain[s][ch]);
            end
         end
      conv_done = 1; @(negedge clk); conv_done = 0;
   endtask

   task automatic push_words();
      for (int k = 0; k < nev; k++) begin
         for (int b = 11; b >= 0; b--) exp_q.push_back(1'(tags[k] >> b));
         for (int ch = 0; ch < 2; ch++) begin
            for (int b = 11; b >= 0; b--) exp_q.push_back(mval[k][ch][b]);
            exp_q.push_back(mgain[k][ch]);
         end
      end
   endtask

   task automatic readout(input string req);
      int cyc = 0;
      push_words();
      token_in = 1; @(negedge clk); token_in = 0;
      if (nev == 0) begin
         check(token_out == 1, {req, " R4 token_out after empty"}, int'(token_out), 1);
         check(bus_oe == 0, {req, " R4 no oe when empty"}, int'(bus_oe), 0);
      end else begin
         while (bus_oe && cyc < 2000) begin cyc++; @(negedge clk); end
         check(cyc == nev * W, {req, " R5 oe length"}, cyc, nev * W);
         check(token_out == 1, {req, " R5 token_out after last bit"}, int'(token_out), 1);
      end
      @(negedge clk);
      check(token_out == 0, {req, " R5 token_out one cycle"}, int'(token_out), 0);
      check(exp_q.size() == 0, {req, " R6 all bits sent"}, exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         check(0, "watchdog expired", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(bus_oe == 0, "R9 oe at reset", int'(bus_oe), 0);
      check(bus_dout == 0, "R9 dout at reset", int'(bus_dout), 0);
      check(token_out == 0, "R9 token_out at reset", int'(token_out), 0);
      rst_n = 1; @(negedge clk);

      // R1: trigger while idle is not stored
      trig = 1; @(negedge clk); trig = 0;

      // Scenario A: three events, tags 5, 8, 8
      begin_acq();
      ticks(5); fire(); ticks(3); fire(); fire();
      // R8: token during acquisition ignored
      token_in = 1; @(negedge clk); token_in = 0;
      for (int i = 0; i < 3; i++) begin
         check(bus_oe == 0 && token_out == 0, "R8 token in acquisition", int'({bus_oe, token_out}), 0);
         @(negedge clk);
      end
      end_acq();
      // R8: token during conversion ignored
      token_in = 1; @(negedge clk); token_in = 0;
      check(bus_oe == 0 && token_out == 0, "R8 token in conversion", int'({bus_oe, token_out}), 0);
      @(negedge clk);
      check(token_out == 0, "R8 no late token_out", int'(token_out), 0);
      fill(1, 0);
      readout("A R1 R2 R3");

      // Scenario B: 18 triggers, only 16 kept (R3); conv write in acquisition ignored (R1); refill from slot 0 (R7)
      begin_acq();
      cwrite(0, 0, 12'hABC, 1'b1);
      for (int i = 0; i < 18; i++) begin fire(); ticks(1); end
      check(nev == 16, "R3 model capped", nev, 16);
      end_acq();
      fill(2, 1);
      readout("B R3 R7 R1");

      // Scenario C: counter wraps after 4097 ticks -> tag 1 (R2)
      begin_acq();
      ticks(4097); fire();
      check(tags[0] == 1, "R2 wrap model", tags[0], 1);
      end_acq();
      fill(3, 0);
      readout("C R2");

      // Scenario D: no triggers -> immediate pass (R4, R7)
      begin_acq();
      ticks(4);
      end_acq();
      fill(4, 0);
      readout("D R7");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule